// File: doc/BRIEF.md
# Receiver Line Validity Detector

This block watches a set of per-line validity flags, one for each serial receiver input, and reduces them to one registered, active-high status. Each flag comes from an analog comparator elsewhere and is high while that line carries a level large enough to count as a real RS-232 signal. The status reports whether at least one line currently carries such a level. A line left floating, for example by an unplugged cable, is pulled to ground and therefore reads as invalid.

The two directions are qualified differently. The status falls only after every line has stayed invalid for a long persistence window, `FALL_CYCLES` clock cycles, which stands for about 30 µs. It rises once any one line has stayed valid for a short window, `RISE_CYCLES` cycles, which stands for about 1 µs. A change in the other direction during either window restarts that window. The status runs in every power mode and has no direct effect on anything else. It can be wired to both the force-on and force-off controls of a powerdown controller, so that the interface turns off once the lines have gone quiet and turns back on when a signal appears.

The flags come from another clock domain. They pass through a two-flop synchronizer before they are qualified.

Top module: `line_valid_det`

## Requirements
- R1: While `rst_ni` is low, `status_o` is 0, and it drops to 0 at once when reset is asserted. After reset is released with all flags low, it stays 0.
- R2: Suppose `status_o` is 0 and the OR of `line_valid_i` changes to 1 just before clock edge 1 and stays 1. Then `status_o` becomes 1 at edge `RISE_CYCLES`+2, counted as two synchronizer stages plus `RISE_CYCLES` qualification edges, and not earlier.
- R3: Suppose `status_o` is 1 and `line_valid_i` becomes all zeros just before edge 1 and stays so. Then `status_o` becomes 0 at edge `FALL_CYCLES`+2 and not earlier.
- R4: If any flag is seen high during the fall window, the fall count restarts from zero. A later all-invalid period then needs the full `FALL_CYCLES`+2 edges.
- R5: If all flags are seen low during the rise window, the rise is cancelled and `status_o` stays 0. A later valid period needs the full `RISE_CYCLES`+2 edges.
- R6: Any single line is enough to raise the status. While at least one flag stays high, dropping or adding other flags does not lower `status_o`.
- R7: `status_o` changes only on the clock edge that completes an uninterrupted qualification window in the direction opposite to its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_valid_i | input | N_LINES | Per-line validity flags from the comparators, asynchronous |
| status_o | output | 1 | High while at least one line is qualified valid |

## Verification
Embedded properties check on every cycle that the status rises only after the synchronized OR was high, and falls only after it was low. They also check that any status change lands exactly on a completed qualification window, and that a valid line seen during a fall window clears the count. Only the bench scenarios can show the exact edge on which the status changes in each direction. The same holds for window restarts and cancellations under short pulses, for each line alone raising the status, and for behaviour across a reset in the middle of operation.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  typedef enum logic {
    ST_INVALID = 1'b0,
    ST_VALID   = 1'b1
  } lvd_state_e;

  function automatic int cnt_bits(input int max_val);
    int b;
    b = 1;
    while ((1 << b) <= max_val) b++;
    return b;
  endfunction
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/lvd_window_timer.sv
module lvd_window_timer #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == limit_i - CW'(1));
  assign done_o = run_i && last;
  assign cnt_o  = cnt_q;

  // restart on any break in the condition and after each completed window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || last)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
endmodule

// File: rtl/line_valid_det.sv
module line_valid_det
  import lvd_pkg::*;
#(
  parameter int N_LINES     = 4,
  parameter int FALL_CYCLES = 300,
  parameter int RISE_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_valid_i,
  output logic               status_o
);
  localparam int MAX_WIN = (FALL_CYCLES > RISE_CYCLES) ? FALL_CYCLES : RISE_CYCLES;
  localparam int CW      = cnt_bits(MAX_WIN);

  logic [N_LINES-1:0] valid_s;
  logic               any_valid;
  logic               run;
  logic               done;
  logic [CW-1:0]      limit;
  logic [CW-1:0]      cnt;
  lvd_state_e         state_q;

  lvd_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_valid_i),
    .q_o   (valid_s)
  );

  assign any_valid = |valid_s;

  // qualify the condition that opposes the current status
  always_comb begin
    if (state_q == ST_VALID) begin
      run   = !any_valid;
      limit = CW'(FALL_CYCLES);
    end else begin
      run   = any_valid;
      limit = CW'(RISE_CYCLES);
    end
  end

  lvd_window_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .limit_i(limit),
    .done_o (done),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= ST_INVALID;
    else if (done) state_q <= (state_q == ST_VALID) ? ST_INVALID : ST_VALID;
  end

  assign status_o = (state_q == ST_VALID);

  p_rise_after_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(any_valid));

  p_fall_after_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $past(!any_valid));

  p_fall_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && any_valid) |=> (cnt == '0));

  p_rise_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && !any_valid) |=> (cnt == '0) && !status_o);

  p_change_on_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != $past(status_o)) |->
      ($past(cnt) == (($past(status_o) ? CW'(FALL_CYCLES) : CW'(RISE_CYCLES)) - CW'(1))));
endmodule

// File: tb/sim_line_valid_det.sv
module sim_line_valid_det;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int FW  = 300;
  localparam int RW  = 10;
  localparam int NV  = 14;

  typedef struct packed {
    logic [N-1:0] pat;
    int           hold;
    logic         exp;
    int           req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'b0000, 20,     1'b0, 1},
    '{4'b0100, RW+1,   1'b0, 2},
    '{4'b0100, 1,      1'b1, 2},
    '{4'b0110, 50,     1'b1, 6},
    '{4'b0000, FW+1,   1'b1, 3},
    '{4'b0000, 1,      1'b0, 3},
    '{4'b1000, 5,      1'b0, 5},
    '{4'b0000, 40,     1'b0, 5},
    '{4'b0001, RW+1,   1'b0, 5},
    '{4'b0001, 1,      1'b1, 5},
    '{4'b0000, 100,    1'b1, 4},
    '{4'b0010, 3,      1'b1, 4},
    '{4'b0000, FW+1,   1'b1, 4},
    '{4'b0000, 1,      1'b0, 4}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] line_valid = '0;
  logic         status;
  int           n_run = 0;
  int           n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_valid_det #(.N_LINES(N), .FALL_CYCLES(FW), .RISE_CYCLES(RW)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .line_valid_i(line_valid),
    .status_o    (status)
  );

  task automatic check(input logic exp, input string req);
    n_run++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s: status_o=%b expected %b at %0t", req, status, exp, $time);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    line_valid = 4'b1111;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    line_valid = '0;
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      line_valid = VECS[i].pat;
      hold(VECS[i].hold);
      check(VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R6: each line alone raises the status
    for (int l = 0; l < N; l++) begin
      line_valid = N'(1) << l;
      hold(RW+1);
      check(1'b0, "R2 single line early");
      hold(1);
      check(1'b1, "R6 single line");
      line_valid = '0;
      hold(FW+2);
      check(1'b0, "R3 single line fall");
    end

    // R1: reset in the middle of operation
    line_valid = 4'b1001;
    hold(RW+2);
    check(1'b1, "R1 pre");
    #1 rst_ni = 1'b0;
    #1 check(1'b0, "R1 async");
    line_valid = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    hold(RW+5);
    check(1'b0, "R1 post");

    // R7: no change without a full window, short glitches ignored
    for (int g = 0; g < 5; g++) begin
      line_valid = 4'b0100;
      hold(RW-1);
      line_valid = '0;
      hold(4);
    end
    check(1'b0, "R7 glitches");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule